// File: doc/BRIEF.md
# Microinstruction Cycle Phase Generator

This block paces a microcoded controller. Each microinstruction runs through a fixed cycle of equal timing intervals. A start request launches a single marker pulse. That pulse then walks down a chain of timing flops and gives four non-overlapping phase pulses in turn: the first phase, the second phase, the data strobe and the third phase. Surrounding logic uses them to capture branch conditions, to load branch targets and transfer sources, to commit results, and to fetch the next control word.

An in-progress flag covers the working part of the cycle and drops for one interval at the 250 ns point. In that release window either a queued microcode start or a waiting host access can take over. The host always wins the window. For RAM operations the block sends an 80 ns write enable that begins with the first phase, or a read capture pulse that lines up with the second phase. The block runs on a fine clock. `PHASE_TICKS` fine clocks make one interval, and the defaults of 5 and 8 ticks at 100 MHz give 50 ns intervals and an 80 ns write pulse.

Top module: `mcyc_phase_gen`

## Requirements
- R1: During reset, every output is low.
- R2: The first-phase pulse is high for exactly `PHASE_TICKS` consecutive clocks (one interval).
- R3: The second phase, the data strobe and the third phase follow the first phase in that order. Each is one interval long and there is no gap between them. At most one of the four phases is high at any time.
- R4: The in-progress flag rises in the clock where the first phase rises. It stays high for five intervals, dropping `5*PHASE_TICKS` clocks after that rise.
- R5: When a start is waiting, the next first phase rises exactly one interval after the flag drops. The cycle-to-cycle spacing is then `6*PHASE_TICKS` clocks.
- R6: A start pulse that arrives while a cycle is in progress is held and not lost. Several such pulses during one cycle merge into a single following cycle.
- R7: A start pulse given while the block is idle produces a first phase within `PHASE_TICKS+1` clocks.
- R8: A host request made while the block is idle is acknowledged within `PHASE_TICKS+1` clocks. While the acknowledge is high, no cycle starts; a start given in that time waits until the request is withdrawn.
- R9: A host request raised during a cycle is acknowledged at the end of the release window, `6*PHASE_TICKS` clocks after that cycle's first phase rose. The acknowledge is never high while the flag is high, and the host takes the window ahead of a waiting start.
- R10: If `ram_op_i`=1 and `ram_wr_i`=1 at the boundary where a first phase begins, the write enable is high for exactly `WR_TICKS` clocks, starting in the clock where the first phase rises.
- R11: If `ram_op_i`=1 and `ram_wr_i`=0 at that boundary, the read capture pulse is high exactly while the second phase is high, and the write enable stays low.
- R12: If `ram_op_i`=0 at that boundary, neither the write enable nor the read capture pulse is asserted during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fine timing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-clock request to run a microinstruction cycle |
| host_req_i | input | 1 | Host access request, held as a level |
| ram_op_i | input | 1 | The instruction being launched is a RAM operation |
| ram_wr_i | input | 1 | RAM direction: 1 write, 0 read |
| ph1_o | output | 1 | First phase pulse |
| ph2_o | output | 1 | Second phase pulse |
| strobe_o | output | 1 | Data strobe pulse |
| ph3_o | output | 1 | Third phase pulse |
| busy_o | output | 1 | Microinstruction in progress |
| host_ack_o | output | 1 | Host owns the shared resources |
| ram_wr_en_o | output | 1 | Stretched RAM write enable |
| ram_rd_cap_o | output | 1 | RAM read data capture pulse |

## Verification
The properties rest on a few assumptions about the inputs:
- `start_i` arrives as single-clock pulses on the fine clock.
- `host_req_i` is a level that is held until acknowledged and then withdrawn.
- The RAM operation and direction are stable at the interval boundary where a cycle launches.
- `6*PHASE_TICKS` exceeds `WR_TICKS`, so a write pulse ends inside its own cycle.

The stimulus keeps to these rules. It drives all inputs on the falling edge, keeps the RAM inputs constant from a start request until its cycle has ended, and holds the host request across whole windows. Start pulses are placed at several offsets within the interval so that launch timing is exercised against every position of the interval counter.

// File: rtl/mcyc_phase_pkg.sv
package mcyc_phase_pkg;
  localparam int unsigned NUM_STAGES = 5;

  // stage order is the timing sequence
  typedef enum logic [2:0] {
    STG_PH1    = 3'd0,
    STG_PH2    = 3'd1,
    STG_STROBE = 3'd2,
    STG_PH3    = 3'd3,
    STG_TAIL   = 3'd4
  } stage_e;

  typedef struct packed {
    logic ph1;
    logic ph2;
    logic strobe;
    logic ph3;
  } phases_t;
endpackage

// File: rtl/mcyc_interval_tick.sv
module mcyc_interval_tick #(
  parameter int unsigned PHASE_TICKS = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (PHASE_TICKS > 1) ? $clog2(PHASE_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_TICKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/mcyc_seq.sv
module mcyc_seq
  import mcyc_phase_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic                  start_i,
  input  logic                  host_req_i,
  output logic [NUM_STAGES-1:0] stage_o,
  output logic                  busy_o,
  output logic                  host_ack_o,
  output logic                  launch_o
);
  logic                  pend_q, busy_q, host_q;
  logic [NUM_STAGES-1:0] stg_q;
  logic                  launch;

  // host holds off microcode; start only at an interval boundary
  assign launch = tick_i & ~busy_q & ~host_q & ~host_req_i & pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (start_i) pend_q <= 1'b1;
    else if (launch)  pend_q <= 1'b0;
  end

  // self-clearing start stage, then the shift chain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stg_q[0] <= 1'b0;
    else if (tick_i) stg_q[0] <= launch;
  end

  for (genvar i = 1; i < NUM_STAGES; i++) begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[i] <= 1'b0;
      else if (tick_i) stg_q[i] <= stg_q[i-1];
    end
  end

  // in-progress drops when the tail stage leaves
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  busy_q <= 1'b0;
    else if (launch)                              busy_q <= 1'b1;
    else if (tick_i && stg_q[int'(STG_TAIL)])     busy_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) host_q <= 1'b0;
    else if (tick_i) begin
      if (host_q)                       host_q <= host_req_i;
      else if (!busy_q && host_req_i)   host_q <= 1'b1;
    end
  end

  assign stage_o    = stg_q;
  assign busy_o     = busy_q;
  assign host_ack_o = host_q;
  assign launch_o   = launch;
endmodule

// File: rtl/mcyc_ram_pulse.sv
module mcyc_ram_pulse #(
  parameter int unsigned WR_TICKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic ram_op_i,
  input  logic ram_wr_i,
  input  logic ph2_i,
  output logic wr_en_o,
  output logic rd_cap_o
);
  localparam int unsigned WCW = $clog2(WR_TICKS + 1);
  localparam logic [WCW-1:0] WR_LOAD = WCW'(WR_TICKS);

  logic [WCW-1:0] wcnt_q;
  logic           rd_q;

  // write width counted in fine clocks, not aligned to intervals
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             wcnt_q <= '0;
    else if (launch_i && ram_op_i && ram_wr_i) wcnt_q <= WR_LOAD;
    else if (wcnt_q != '0)                   wcnt_q <= wcnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rd_q <= 1'b0;
    else if (launch_i) rd_q <= ram_op_i & ~ram_wr_i;
  end

  assign wr_en_o  = (wcnt_q != '0);
  assign rd_cap_o = rd_q & ph2_i;
endmodule

// File: rtl/mcyc_phase_gen.sv
module mcyc_phase_gen
  import mcyc_phase_pkg::*;
#(
  parameter int unsigned PHASE_TICKS = 5,
  parameter int unsigned WR_TICKS    = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic host_req_i,
  input  logic ram_op_i,
  input  logic ram_wr_i,
  output logic ph1_o,
  output logic ph2_o,
  output logic strobe_o,
  output logic ph3_o,
  output logic busy_o,
  output logic host_ack_o,
  output logic ram_wr_en_o,
  output logic ram_rd_cap_o
);
  logic                  tick;
  logic                  launch;
  logic [NUM_STAGES-1:0] stage;
  phases_t               ph;

  mcyc_interval_tick #(.PHASE_TICKS(PHASE_TICKS)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  mcyc_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .start_i    (start_i),
    .host_req_i (host_req_i),
    .stage_o    (stage),
    .busy_o     (busy_o),
    .host_ack_o (host_ack_o),
    .launch_o   (launch)
  );

  assign ph.ph1    = stage[int'(STG_PH1)];
  assign ph.ph2    = stage[int'(STG_PH2)];
  assign ph.strobe = stage[int'(STG_STROBE)];
  assign ph.ph3    = stage[int'(STG_PH3)];

  mcyc_ram_pulse #(.WR_TICKS(WR_TICKS)) u_ram (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .ram_op_i (ram_op_i),
    .ram_wr_i (ram_wr_i),
    .ph2_i    (ph.ph2),
    .wr_en_o  (ram_wr_en_o),
    .rd_cap_o (ram_rd_cap_o)
  );

  assign ph1_o    = ph.ph1;
  assign ph2_o    = ph.ph2;
  assign strobe_o = ph.strobe;
  assign ph3_o    = ph.ph3;
endmodule

// File: rtl/mcyc_phase_gen_chk.sv
module mcyc_phase_gen_chk #(
  parameter int unsigned PHASE_TICKS = 5,
  parameter int unsigned WR_TICKS    = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ph1_o,
  input logic ph2_o,
  input logic strobe_o,
  input logic ph3_o,
  input logic busy_o,
  input logic host_ack_o,
  input logic ram_wr_en_o,
  input logic ram_rd_cap_o
);
  logic [15:0] ph1_run_q, wr_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph1_run_q <= '0;
      wr_run_q  <= '0;
    end else begin
      ph1_run_q <= ph1_o       ? ph1_run_q + 16'd1 : 16'd0;
      wr_run_q  <= ram_wr_en_o ? wr_run_q  + 16'd1 : 16'd0;
    end
  end

  // R2
  ph1_not_long_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph1_o |-> ph1_run_q < 16'(PHASE_TICKS));
  // R2
  ph1_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ph1_o && ph1_run_q != 16'd0) |-> ph1_run_q == 16'(PHASE_TICKS));
  // R3
  phase_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ph1_o, ph2_o, strobe_o, ph3_o}));
  // R3
  ph2_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ph1_o) |-> ph2_o);
  // R3
  strobe_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ph2_o) |-> strobe_o);
  // R3
  ph3_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strobe_o) |-> ph3_o);
  // R4
  busy_with_ph1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ph1_o) |-> $rose(busy_o));
  // R4
  busy_covers_ph3_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph3_o |-> busy_o);
  // R9
  host_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ack_o |-> !busy_o && !ph1_o);
  // R10
  wr_starts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_wr_en_o) |-> $rose(ph1_o));
  // R10
  wr_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_wr_en_o && wr_run_q != 16'd0) |-> wr_run_q == 16'(WR_TICKS));
  // R11
  rd_in_ph2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_rd_cap_o |-> ph2_o && !ram_wr_en_o);
endmodule

bind mcyc_phase_gen mcyc_phase_gen_chk #(
  .PHASE_TICKS(PHASE_TICKS),
  .WR_TICKS   (WR_TICKS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ph1_o        (ph1_o),
  .ph2_o        (ph2_o),
  .strobe_o     (strobe_o),
  .ph3_o        (ph3_o),
  .busy_o       (busy_o),
  .host_ack_o   (host_ack_o),
  .ram_wr_en_o  (ram_wr_en_o),
  .ram_rd_cap_o (ram_rd_cap_o)
);

// File: tb/mcyc_phase_gen_bench.sv
module mcyc_phase_gen_bench;
  localparam int P   = 5;
  localparam int W   = 8;
  localparam int CYC = 6 * P;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start = 1'b0, host_req = 1'b0, ram_op = 1'b0, ram_wr = 1'b0;
  logic ph1, ph2, strobe, ph3, busy, host_ack, wr_en, rd_cap;

  always #10 clk = ~clk;

  mcyc_phase_gen #(.PHASE_TICKS(P), .WR_TICKS(W)) u_mcyc_phase_gen (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .host_req_i(host_req),
    .ram_op_i(ram_op), .ram_wr_i(ram_wr),
    .ph1_o(ph1), .ph2_o(ph2), .strobe_o(strobe), .ph3_o(ph3),
    .busy_o(busy), .host_ack_o(host_ack),
    .ram_wr_en_o(wr_en), .ram_rd_cap_o(rd_cap)
  );

  typedef struct packed { logic wr; logic rd; } exp_t;
  exp_t expq[$];

  int checks = 0, errors = 0;
  int clk_cnt = 0, last_rise = -1, last_gap = 0, cycles_seen = 0;
  bit done = 0;

  always @(posedge clk) clk_cnt <= clk_cnt + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic expect_cycle(input logic wr, input logic rd);
    exp_t e;
    e.wr = wr;
    e.rd = rd;
    expq.push_back(e);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // monitor: pops one expected item per observed cycle
  initial begin
    bit prev = 0;
    @(posedge rst_ni);
    forever begin
      @(negedge clk);
      if (ph1 && !prev) begin
        exp_t e;
        int bad_w = 0, bad_seq = 0, bad_busy = 0, bad_wr = 0, bad_rd = 0;
        cycles_seen++;
        if (last_rise >= 0) last_gap = clk_cnt - last_rise;
        last_rise = clk_cnt;
        if (expq.size() == 0) begin
          check(0, "R6", "unexpected cycle", 1, 0);
          e = '0;
        end else e = expq.pop_front();
        for (int k = 0; k < CYC; k++) begin
          if (k > 0) @(negedge clk);
          if (ph1 !== (k < P)) bad_w++;
          if (ph2 !== (k >= P && k < 2*P) || strobe !== (k >= 2*P && k < 3*P) ||
              ph3 !== (k >= 3*P && k < 4*P)) bad_seq++;
          if (busy !== (k < 5*P)) bad_busy++;
          if (wr_en !== (e.wr && k < W)) bad_wr++;
          if (rd_cap !== (e.rd && k >= P && k < 2*P)) bad_rd++;
          prev = ph1;
        end
        check(bad_w == 0, "R2", "ph1 width mismatches", bad_w, 0);
        check(bad_seq == 0, "R3", "phase order mismatches", bad_seq, 0);
        check(bad_busy == 0, "R4", "busy window mismatches", bad_busy, 0);
        check(bad_wr == 0, e.wr ? "R10" : "R12", "write enable mismatches", bad_wr, 0);
        check(bad_rd == 0, e.rd ? "R11" : "R12", "read capture mismatches", bad_rd, 0);
      end else prev = ph1;
    end
  end

  initial begin
    #(20 * 150000);
    check(0, "WD", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int n0, lat;
    settle(3);
    // R1
    check({ph1, ph2, strobe, ph3, busy, host_ack, wr_en, rd_cap} == 8'h00,
          "R1", "outputs in reset", {ph1, ph2, strobe, ph3, busy, host_ack, wr_en, rd_cap}, 0);
    rst_ni = 1'b1;
    settle(2);

    // plain cycle, no RAM op (R12)
    expect_cycle(0, 0);
    pulse_start();
    settle(CYC + 2*P);

    // write cycle (R10)
    ram_op = 1'b1; ram_wr = 1'b1;
    expect_cycle(1, 0);
    pulse_start();
    settle(CYC + 2*P);

    // read cycle (R11)
    ram_wr = 1'b0;
    expect_cycle(0, 1);
    pulse_start();
    settle(CYC + 2*P);
    ram_op = 1'b0;

    // idle launch latency at every interval offset (R7)
    for (int s = 0; s < P; s++) begin
      settle(s);
      expect_cycle(0, 0);
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      lat = 1;
      while (!ph1 && lat < 3*P) begin
        @(negedge clk);
        lat++;
      end
      check(lat >= 1 && lat <= P + 1, "R7", "idle start latency", lat, P + 1);
      settle(CYC + P);
    end

    // back-to-back with merged pending starts (R5, R6)
    ram_op = 1'b1; ram_wr = 1'b0;
    n0 = cycles_seen;
    expect_cycle(0, 1);
    expect_cycle(0, 1);
    pulse_start();
    while (!ph1) @(negedge clk);
    settle(P);
    pulse_start();
    settle(P);
    pulse_start();
    settle(2*CYC + 2*P);
    check(last_gap == CYC, "R5", "first phase spacing", last_gap, CYC);
    check(cycles_seen - n0 == 2, "R6", "cycles from three starts", cycles_seen - n0, 2);
    check(expq.size() == 0, "R6", "pending start lost", expq.size(), 0);
    ram_op = 1'b0;

    // host while idle (R8)
    n0 = cycles_seen;
    @(negedge clk) host_req = 1'b1;
    lat = 0;
    while (!host_ack && lat < 3*P) begin
      @(negedge clk);
      lat++;
    end
    check(lat >= 1 && lat <= P + 1, "R8", "host ack latency", lat, P + 1);
    pulse_start();
    settle(3*P);
    check(host_ack && !busy && !ph1, "R8", "start held off by host",
          {host_ack, busy, ph1}, 3'b100);
    check(cycles_seen == n0, "R8", "cycles during host", cycles_seen - n0, 0);
    expect_cycle(0, 0);
    @(negedge clk) host_req = 1'b0;
    settle(CYC + 3*P);
    check(cycles_seen - n0 == 1, "R8", "held start ran after host", cycles_seen - n0, 1);
    check(!host_ack, "R8", "host ack withdrawn", host_ack, 0);

    // host during a cycle takes the release window (R9)
    n0 = cycles_seen;
    expect_cycle(0, 0);
    pulse_start();
    while (!ph1) @(negedge clk);
    settle(P);
    host_req = 1'b1;
    pulse_start();
    lat = 0;
    while (!host_ack && lat < 3*CYC) begin
      @(negedge clk);
      lat++;
    end
    check(clk_cnt - last_rise == CYC, "R9", "host ack after ph1", clk_cnt - last_rise, CYC);
    settle(2*P);
    check(host_ack && !busy && !ph1, "R9", "host wins release window",
          {host_ack, busy, ph1}, 3'b100);
    check(cycles_seen - n0 == 1, "R9", "cycles before host release", cycles_seen - n0, 1);
    expect_cycle(0, 0);
    @(negedge clk) host_req = 1'b0;
    settle(2*CYC);
    check(cycles_seen - n0 == 2, "R9", "pending start after host", cycles_seen - n0, 2);
    check(expq.size() == 0, "R9", "expected cycles left", expq.size(), 0);

    finish_run();
  end
endmodule